// File: doc/BRIEF.md
# Fan Tachometer Period Measurement Unit

This block measures the rotation period of one fan at a time, chosen from up to sixteen tachometer inputs. Every tach input is resynchronised into the core clock and watched for edges. Software starts a capture in two steps. It first writes a zero trigger word, which arms the unit. It then writes a word with exactly one bit set, which names the channel to measure.

The settings for a channel come from a clock type. Each channel has a 3-bit source field that names a PWM port. That port is assigned to one of three clock types. The type supplies the edge sensitivity and the tach clock divider.

After the trigger, the unit waits for the first qualifying edge. It then counts divided-clock ticks until the next qualifying edge. It posts the count in the low 20 bits of a result word and sets a completion flag in bit 31. If the counter reaches its ceiling before the closing edge, the unit finishes with the ceiling value, which signals a stopped fan. RPM arithmetic and bus access are left to the surrounding logic.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset the result word is all zero and `busy` is low.
- R2: A nonzero trigger write that is not preceded by a zero write since the last accepted trigger is ignored. The result word and `busy` keep their values.
- R3: A one-hot trigger with bit n set measures channel n only. Edges on other tach inputs do not affect the result. Completion is only reached from a busy measurement.
- R4: The tick divider is 4 << (2 * div), where div is the 2-bit division field of the type. The result is floor(P / divider), where P is the number of core clocks between the opening edge and the closing edge.
- R5: Edge mode 00 selects falling edges and mode 01 selects rising edges; both measure a full tach period. Mode 10 uses both edges, so a 50 % duty input gives half the period.
- R6: Edge mode 11 is reserved. No edge qualifies, so the measurement ends with the saturation value.
- R7: If the count reaches CNT_MAX (default 0xFFFFF) before the closing edge, the unit reports done with CNT_MAX. The reported count never exceeds CNT_MAX.
- R8: The 3-bit source of channel n is {src_hi[n], src_lo[2n+1:2n]}, and it names a PWM port p. The clock type of that port is port_type[2p+1:2p], with values 0 to 2. The mode field of type t is type_mode[2t+1:2t] and its divider field is type_div[2t+1:2t].
- R9: An armed trigger that is not one-hot, or that names a disabled channel (ch_en) or a disabled or invalid type (type_en, type 3), clears done and starts nothing.
- R10: An accepted trigger clears done in the next cycle and aborts any measurement in progress.
- R11: The result word is {done, 11'b0, count[19:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_in | input | NCH | Raw tachometer inputs |
| ch_en | input | NCH | Per-channel enable |
| src_lo | input | 2*NCH | Low two bits of each channel's PWM source |
| src_hi | input | NCH | Top bit of each channel's PWM source |
| port_type | input | 2*NPORT | Clock type of each PWM port |
| type_en | input | NTYPE | Per-type enable |
| type_mode | input | 2*NTYPE | Edge mode of each type |
| type_div | input | 2*NTYPE | Tach divider field of each type |
| trig_we | input | 1 | Trigger write strobe |
| trig_data | input | NCH | Trigger word |
| res_word | output | 32 | Done flag and measured count |
| busy | output | 1 | Measurement in progress |

## Verification
The measured count reflects every internal timing state, so faults show up at the ports. A wrong divider reload, a wrong edge selection or a wrong source-to-type lookup changes the count by a predictable amount. That difference is visible as soon as done rises, one tach period after the opening edge. A broken arm flag or a broken saturation compare shows up in a different way. Either done appears when it must not, or it fails to appear within CNT_MAX divided ticks. The bench bounds every wait, so such a fault surfaces within a few thousand cycles.

// File: rtl/fan_tach_meter.sv
module fan_tach_meter #(
  parameter int NCH     = 16,
  parameter int NPORT   = 8,
  parameter int NTYPE   = 3,
  parameter int CNT_MAX = 20'hFFFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     tach_in,
  input  logic [NCH-1:0]     ch_en,
  input  logic [2*NCH-1:0]   src_lo,
  input  logic [NCH-1:0]     src_hi,
  input  logic [2*NPORT-1:0] port_type,
  input  logic [NTYPE-1:0]   type_en,
  input  logic [2*NTYPE-1:0] type_mode,
  input  logic [2*NTYPE-1:0] type_div,
  input  logic               trig_we,
  input  logic [NCH-1:0]     trig_data,
  output logic [31:0]        res_word,
  output logic               busy
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CW  = 20;

  typedef enum logic [1:0] {IDLE, WAIT, MEAS} phase_t;

  logic [NCH-1:0] s1, s2, s3;
  logic           armed, done;
  phase_t         phase;
  logic [CHW-1:0] idx, ch_q;
  logic [1:0]     mode_q, div_q;
  logic [7:0]     dcnt;
  logic [CW-1:0]  cnt, res_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= tach_in; s2 <= s1; s3 <= s2;
    end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NCH; i++)
      if (trig_data[i]) idx = CHW'(i);
  end

  logic [2:0] sel_src;
  logic [1:0] sel_type;
  logic       one_hot, port_ok, type_ok, accept, start_ok, zero_wr;
  assign sel_src  = {src_hi[idx], src_lo[{idx, 1'b0} +: 2]};
  assign port_ok  = 32'(sel_src) < NPORT;
  assign sel_type = port_ok ? port_type[{sel_src, 1'b0} +: 2] : 2'd3;
  assign type_ok  = (32'(sel_type) < NTYPE) && type_en[sel_type];
  assign one_hot  = (trig_data != '0) && ((trig_data & (trig_data - 1'b1)) == '0);
  assign zero_wr  = trig_we && (trig_data == '0);
  assign accept   = trig_we && armed && (trig_data != '0);
  assign start_ok = accept && one_hot && ch_en[idx] && port_ok && type_ok;

  logic cur, prv, hit;
  assign cur = s2[ch_q];
  assign prv = s3[ch_q];
  always_comb
    case (mode_q)
      2'b00:   hit = prv & ~cur;
      2'b01:   hit = cur & ~prv;
      2'b10:   hit = cur ^ prv;
      default: hit = 1'b0;
    endcase

  logic [7:0]    dlim;
  logic          tick, sat;
  logic [CW:0]   cnt_inc;
  assign dlim    = 8'((9'd4 << {div_q, 1'b0}) - 9'd1);
  assign tick    = (dcnt == dlim);
  assign cnt_inc = {1'b0, cnt} + (CW+1)'(tick);
  assign sat     = cnt_inc >= (CW+1)'(CNT_MAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed   <= 1'b0;
      done    <= 1'b0;
      phase   <= IDLE;
      ch_q    <= '0;
      mode_q  <= '0;
      div_q   <= '0;
      dcnt    <= '0;
      cnt     <= '0;
      res_cnt <= '0;
    end else begin
      if (zero_wr) armed <= 1'b1;
      if (accept) begin
        armed <= 1'b0;
        done  <= 1'b0;
        dcnt  <= '0;
        cnt   <= '0;
        if (start_ok) begin
          phase  <= WAIT;
          ch_q   <= idx;
          mode_q <= type_mode[{sel_type, 1'b0} +: 2];
          div_q  <= type_div[{sel_type, 1'b0} +: 2];
        end else begin
          phase  <= IDLE;
        end
      end else begin
        case (phase)
          WAIT:
            if (hit) begin
              phase <= MEAS;
              dcnt  <= '0;
              cnt   <= '0;
            end else if (sat) begin
              phase   <= IDLE;
              done    <= 1'b1;
              res_cnt <= CW'(CNT_MAX);
            end else begin
              dcnt <= tick ? '0 : dcnt + 8'd1;
              cnt  <= cnt_inc[CW-1:0];
            end
          MEAS:
            if (hit || sat) begin
              phase   <= IDLE;
              done    <= 1'b1;
              res_cnt <= sat ? CW'(CNT_MAX) : cnt_inc[CW-1:0];
            end else begin
              dcnt <= tick ? '0 : dcnt + 8'd1;
              cnt  <= cnt_inc[CW-1:0];
            end
          default: ;
        endcase
      end
    end

  assign busy     = (phase != IDLE);
  assign res_word = {done, 11'd0, res_cnt};
endmodule

// File: rtl/fan_tach_meter_chk.sv
module fan_tach_meter_chk #(
  parameter int NCH     = 16,
  parameter int CNT_MAX = 20'hFFFFF
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trig_we,
  input logic [NCH-1:0] trig_data,
  input logic           armed,
  input logic           busy,
  input logic [31:0]    res_word
);
  assert_clear_on_trigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && armed && (trig_data != '0)) |=> !res_word[31]);

  assert_unarmed_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && !armed && (trig_data != '0) && !busy) |=> $stable(res_word) && !busy);

  assert_count_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_word[19:0] <= 20'(CNT_MAX));

  assert_done_from_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_word[31]) |-> $past(busy));
endmodule

bind fan_tach_meter fan_tach_meter_chk #(.NCH(NCH), .CNT_MAX(CNT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_data(trig_data),
  .armed(armed), .busy(busy), .res_word(res_word)
);

// File: tb/tb_fan_tach_meter.sv
module tb_fan_tach_meter;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16, NPORT = 8, NTYPE = 3, CMAX = 1000;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] tach_in = '0, ch_en = '1, src_hi = '0, trig_data = '0;
  logic [2*NCH-1:0] src_lo = '0;
  logic [2*NPORT-1:0] port_type;
  logic [NTYPE-1:0] type_en = '1;
  logic [2*NTYPE-1:0] type_mode = '0, type_div = '0;
  logic trig_we = 0;
  logic [31:0] res_word;
  logic busy;

  int halfp [NCH];
  int tcnt [NCH];
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fan_tach_meter #(.NCH(NCH), .NPORT(NPORT), .NTYPE(NTYPE), .CNT_MAX(CMAX)) dut (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .ch_en(ch_en), .src_lo(src_lo),
    .src_hi(src_hi), .port_type(port_type), .type_en(type_en), .type_mode(type_mode),
    .type_div(type_div), .trig_we(trig_we), .trig_data(trig_data),
    .res_word(res_word), .busy(busy));

  always @(negedge clk)
    for (int i = 0; i < NCH; i++)
      if (halfp[i] > 0) begin
        tcnt[i]++;
        if (tcnt[i] >= halfp[i]) begin tcnt[i] = 0; tach_in[i] = ~tach_in[i]; end
      end

  function automatic int expect_cnt(int t, int mode, int dv);
    int p = (mode == 2) ? t / 2 : t;
    int v = p / (4 << (2 * dv));
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [NCH-1:0] d);
    trig_data = d; trig_we = 1; step(1); trig_we = 0; trig_data = '0;
  endtask

  task automatic trig(int ch);
    wr('0); wr(NCH'(1) << ch);
  endtask

  task automatic set_src(int ch, int port);
    src_lo[2*ch +: 2] = 2'(port);
    src_hi[ch] = port[2];
  endtask

  task automatic set_type(int t, int mode, int dv);
    type_mode[2*t +: 2] = 2'(mode);
    type_div[2*t +: 2] = 2'(dv);
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int k = 0; k < 20000; k++) begin
      if (res_word[31]) begin ok = 1; break; end
      step(1);
    end
  endtask

  task automatic measure(string req, int ch, int t, int mode, int dv);
    bit ok;
    halfp[ch] = t / 2;
    step(2 * t + 10);
    trig(ch);
    wait_done(ok);
    check(req, {31'd0, ok}, 32'd1);
    check(req, res_word, {1'b1, 11'd0, 20'(expect_cnt(t, mode, dv))});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit ok;
    logic [31:0] keep;
    void'($urandom(32'd2024));
    for (int p = 0; p < NPORT; p++) port_type[2*p +: 2] = 2'(p % 3);
    for (int i = 0; i < NCH; i++) begin halfp[i] = 0; tcnt[i] = 0; set_src(i, i % 8); end
    step(3);
    check("R1 result", res_word, 32'd0);
    check("R1 busy", {31'd0, busy}, 32'd0);
    rst_n = 1;
    step(2);

    // R3 R4 R5 R8: ch3 -> port1 -> type1, rising, div0
    set_type(1, 1, 0);
    halfp[4] = 7;
    set_src(3, 1);
    measure("R3 R5 rising", 3, 40, 1, 0);
    check("R11 reserved bits", {21'd0, res_word[30:20]}, 32'd0);

    // R4: ch0 -> port0 -> type0, falling, div1
    set_type(0, 0, 1); set_src(0, 0);
    measure("R4 div1 falling", 0, 80, 0, 1);

    // R5: both edges
    set_type(0, 2, 0);
    measure("R5 both edges", 0, 48, 2, 0);

    // R8: same channel, source change flips type
    set_type(2, 1, 2); set_type(0, 1, 0);
    set_src(5, 2);
    measure("R8 src port2", 5, 256, 1, 2);
    set_src(5, 0);
    measure("R8 src port0", 5, 256, 1, 0);
    set_src(5, 5); // port5 -> type2
    measure("R8 src port5", 5, 256, 1, 2);

    // R2: unarmed write ignored
    keep = res_word;
    wr(NCH'(1) << 3);
    step(3);
    check("R2 unarmed result", res_word, keep);
    check("R2 unarmed busy", {31'd0, busy}, 32'd0);

    // R7: stopped fan
    halfp[6] = 0; set_src(6, 0);
    trig(6);
    wait_done(ok);
    check("R7 stopped", res_word, {1'b1, 11'd0, 20'(CMAX)});

    // R6: reserved mode
    set_type(1, 3, 0); set_src(7, 1); halfp[7] = 10;
    step(30);
    trig(7);
    wait_done(ok);
    check("R6 reserved mode", res_word, {1'b1, 11'd0, 20'(CMAX)});
    set_type(1, 1, 0);

    // R9: disabled channel, disabled type, multi-hot
    ch_en[8] = 0; trig(8); step(3);
    check("R9 disabled ch done", {31'd0, res_word[31]}, 32'd0);
    check("R9 disabled ch busy", {31'd0, busy}, 32'd0);
    ch_en[8] = 1;
    type_en[1] = 0; set_src(9, 1); trig(9); step(3);
    check("R9 disabled type busy", {31'd0, busy}, 32'd0);
    type_en[1] = 1;
    wr('0); wr(16'h0030); step(3);
    check("R9 multi-hot busy", {31'd0, busy}, 32'd0);
    check("R9 multi-hot done", {31'd0, res_word[31]}, 32'd0);

    // R10: abort a long measurement
    halfp[10] = 0; set_src(10, 0); halfp[11] = 12; set_src(11, 0);
    trig(10); step(50);
    check("R10 busy before abort", {31'd0, busy}, 32'd1);
    wr('0);
    trig_data = NCH'(1) << 11; trig_we = 1; step(1); trig_we = 0;
    check("R10 done cleared", {31'd0, res_word[31]}, 32'd0);
    wait_done(ok);
    check("R10 aborted result", res_word, {1'b1, 11'd0, 20'(expect_cnt(24, 1, 0))});

    // random
    for (int it = 0; it < 24; it++) begin
      int ch = $urandom % NCH;
      int port = $urandom % NPORT;
      int ty = port % 3;
      int md = $urandom % 3;
      int dv = $urandom % 2;
      int t = 2 * (8 + $urandom % 60);
      for (int j = 0; j < NCH; j++) if (j != ch) halfp[j] = 3 + $urandom % 40;
      set_src(ch, port);
      set_type(ty, md, dv);
      measure("R3 R4 R5 R8 random", ch, t, md, dv);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule